// File: doc/BRIEF.md
# Synthesizer Divider Chain With Test Selector

This block is the digital divider path of a clock synthesizer, modelled on one fast system clock. Every slow clock in the path is a one-cycle enable pulse on that clock, and every divided waveform is a register that changes only on such an enable. A fixed prescaler turns reference enables into a ÷16 square wave for the phase comparison point. A programmable feedback divider counts oscillator enables. It toggles its output every M enables, so its waveform runs at the oscillator rate divided by 2·M. An output divider turns oscillator enables into the synthesized output at ÷1, ÷2, ÷4 or ÷8, chosen by a 2-bit code.

A 3-bit test code picks one internal signal, or a constant, for a single test pin. One choice is a second copy of the M divider, clocked by the serial configuration clock. Another is the output divided by four. The M, N and test values come from a configuration block outside this one. A new M or N value is taken only at the end of the current count, so a divided waveform never produces a shortened pulse.

Top module: `synth_div_chain`

## Requirements
- R1: After reset `ref_div_o` is low. Each `ref_en_i` pulse advances a position counter through 0..15, and the first pulse after reset lands on position 0. `ref_div_o` is high for positions 0..7 and low for positions 8..15.
- R2: After reset `fb_o` is low. It toggles on the first `osc_en_i` pulse after reset and then on every M-th pulse, giving a period of 2·M pulses. An M value of 0 acts as 1.
- R3: The output divide code `n_i` maps 2'b00 to ÷2, 2'b01 to ÷4, 2'b10 to ÷8 and 2'b11 to ÷1.
- R4: For ÷2, ÷4 and ÷8, `fout_o` is high for the first D/2 oscillator enables of each period and low for the other D/2. After reset `fout_o` is low, and the first enable starts a period, which drives it high and loads `n_i`.
- R5: In ÷1 mode `fout_o` equals `osc_en_i` in the same cycle.
- R6: `m_i` is sampled only on the enable where `fb_o` toggles. A change made in the middle of a count leaves the current half period at the old length.
- R7: `n_i` is sampled only on the enable that starts a new output period. A change made in the middle of a period leaves that period at the old ratio.
- R8: `t_i` = 3'b000 drives `test_o` from `sreg_i`. `t_i` = 3'b001 drives it high and `t_i` = 3'b101 drives it low.
- R9: `t_i` = 3'b010 selects `ref_div_o`, 3'b011 selects `fb_o` and 3'b100 selects `fout_o`.
- R10: `t_i` = 3'b110 selects a second M divider that follows the R2 rules on `sclk_en_i` pulses. `t_i` = 3'b111 selects the output divided by four. That signal starts low, advances on each output period start, and is high for two periods and low for two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_en_i | input | 1 | Reference clock enable pulse |
| osc_en_i | input | 1 | Oscillator clock enable pulse |
| sclk_en_i | input | 1 | Serial configuration clock enable pulse |
| m_i | input | M_W (9) | Feedback divide value |
| n_i | input | 2 | Output divide code |
| t_i | input | 3 | Test output select code |
| sreg_i | input | 1 | Configuration shift register serial output |
| ref_div_o | output | 1 | Reference ÷16 waveform |
| fb_o | output | 1 | Feedback ÷2M waveform |
| fout_o | output | 1 | Synthesized output waveform |
| test_o | output | 1 | Selected test signal |

## Verification
The hardest case to reach from the ports is a reconfiguration that arrives in the middle of a count. The old value must keep running until the terminal count, and a wrong reload point only shows as one period of the wrong length. Directed sequences set M or N, advance a known number of enables, change the value, and then measure the gap between waveform edges in enables: first the remaining length under the old value, then the new period. A table of configurations then runs every test code against a bench model. The oscillator, reference and serial enables run at three unrelated pulse rates, so that each selected signal is exercised by enables that do not line up with the others.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

  typedef enum logic [1:0] {
    ODIV_2 = 2'b00,
    ODIV_4 = 2'b01,
    ODIV_8 = 2'b10,
    ODIV_1 = 2'b11
  } odiv_code_e;

  typedef enum logic [2:0] {
    TSEL_SREG  = 3'b000,
    TSEL_HIGH  = 3'b001,
    TSEL_REF   = 3'b010,
    TSEL_FB    = 3'b011,
    TSEL_FOUT  = 3'b100,
    TSEL_LOW   = 3'b101,
    TSEL_SFB   = 3'b110,
    TSEL_FOUT4 = 3'b111
  } tsel_e;

  localparam int unsigned ODIV_MAX = 8;
  localparam int unsigned ODIV_PW  = $clog2(ODIV_MAX);

  // non-monotonic code to ratio
  function automatic logic [ODIV_PW:0] odiv_ratio(input logic [1:0] code);
    case (odiv_code_e'(code))
      ODIV_2:  odiv_ratio = (ODIV_PW+1)'(2);
      ODIV_4:  odiv_ratio = (ODIV_PW+1)'(4);
      ODIV_8:  odiv_ratio = (ODIV_PW+1)'(8);
      default: odiv_ratio = (ODIV_PW+1)'(1);
    endcase
  endfunction

endpackage

// File: rtl/fixed_div.sv
module fixed_div #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic wave_o
);
  localparam int unsigned W    = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);
  localparam logic [W-1:0] HALF = W'(DIV / 2);

  logic [W-1:0] pos_q, pos_nxt;
  logic         wave_q;

  assign pos_nxt = (pos_q == LAST) ? '0 : pos_q + W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= LAST;
      wave_q <= 1'b0;
    end else if (en_i) begin
      pos_q  <= pos_nxt;
      wave_q <= (pos_nxt < HALF);
    end
  end

  assign wave_o = wave_q;
endmodule

// File: rtl/m_div.sv
module m_div #(
  parameter int unsigned M_W = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [M_W-1:0] m_i,
  output logic           wave_o
);
  logic [M_W-1:0] cnt_q, load_val;
  logic           wave_q;

  // M of zero behaves as one
  assign load_val = (m_i == '0) ? '0 : m_i - M_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else if (en_i) begin
      if (cnt_q == '0) begin
        cnt_q  <= load_val;
        wave_q <= ~wave_q;
      end else begin
        cnt_q  <= cnt_q - M_W'(1);
      end
    end
  end

  assign wave_o = wave_q;
endmodule

// File: rtl/out_div.sv
module out_div
  import synth_div_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] code_i,
  output logic       wave_o,
  output logic       tick_o,
  output logic       div1_o
);
  localparam logic [1:0]         RST_CODE = ODIV_2;
  localparam logic [ODIV_PW-1:0] RST_POS  = ODIV_PW'(1);

  logic [1:0]         code_q;
  logic [ODIV_PW:0]   ratio, half;
  logic [ODIV_PW-1:0] pos_q, pos_inc;
  logic               wrap, wave_q;

  assign ratio   = odiv_ratio(code_q);
  assign half    = ratio >> 1;
  assign pos_inc = pos_q + ODIV_PW'(1);
  assign wrap    = ({1'b0, pos_q} == ratio - (ODIV_PW+1)'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= RST_CODE;
      pos_q  <= RST_POS;
      wave_q <= 1'b0;
    end else if (en_i) begin
      if (wrap) begin
        code_q <= code_i;
        pos_q  <= '0;
        wave_q <= 1'b1;
      end else begin
        pos_q  <= pos_inc;
        wave_q <= ({1'b0, pos_inc} < half);
      end
    end
  end

  assign div1_o = (code_q == ODIV_1);
  assign tick_o = en_i & wrap;
  assign wave_o = div1_o ? en_i : wave_q;
endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain
  import synth_div_pkg::*;
#(
  parameter int unsigned M_W     = 9,
  parameter int unsigned PRE_DIV = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ref_en_i,
  input  logic           osc_en_i,
  input  logic           sclk_en_i,
  input  logic [M_W-1:0] m_i,
  input  logic [1:0]     n_i,
  input  logic [2:0]     t_i,
  input  logic           sreg_i,
  output logic           ref_div_o,
  output logic           fb_o,
  output logic           fout_o,
  output logic           test_o
);
  localparam int unsigned NUM_MDIV = 2;
  localparam int unsigned FOUT_SUB = 4;

  logic [NUM_MDIV-1:0] m_en, m_wave;
  logic fout_tick, div1_w, sfb_w, fout4_w;

  fixed_div #(.DIV(PRE_DIV)) u_pre (
    .clk_i, .rst_ni, .en_i(ref_en_i), .wave_o(ref_div_o)
  );

  // index 0: oscillator feedback, index 1: serial clock copy for test
  assign m_en = {sclk_en_i, osc_en_i};

  for (genvar g = 0; g < NUM_MDIV; g++) begin : g_mdiv
    m_div #(.M_W(M_W)) u_mdiv (
      .clk_i, .rst_ni, .en_i(m_en[g]), .m_i, .wave_o(m_wave[g])
    );
  end

  assign fb_o  = m_wave[0];
  assign sfb_w = m_wave[1];

  out_div u_odiv (
    .clk_i, .rst_ni, .en_i(osc_en_i), .code_i(n_i),
    .wave_o(fout_o), .tick_o(fout_tick), .div1_o(div1_w)
  );

  fixed_div #(.DIV(FOUT_SUB)) u_fout4 (
    .clk_i, .rst_ni, .en_i(fout_tick), .wave_o(fout4_w)
  );

  always_comb begin
    unique case (tsel_e'(t_i))
      TSEL_SREG:  test_o = sreg_i;
      TSEL_HIGH:  test_o = 1'b1;
      TSEL_REF:   test_o = ref_div_o;
      TSEL_FB:    test_o = fb_o;
      TSEL_FOUT:  test_o = fout_o;
      TSEL_LOW:   test_o = 1'b0;
      TSEL_SFB:   test_o = sfb_w;
      default:    test_o = fout4_w;
    endcase
  end
endmodule

// File: rtl/synth_div_chk.sv
module synth_div_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ref_en_i,
  input logic       osc_en_i,
  input logic       sclk_en_i,
  input logic [2:0] t_i,
  input logic       ref_div_o,
  input logic       fb_o,
  input logic       fout_o,
  input logic       test_o,
  input logic       div1_w,
  input logic       sfb_w
);
  a_r1_ref_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_en_i |=> $stable(ref_div_o));

  a_r2_fb_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> $stable(fb_o));

  a_r4_fout_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_i && !div1_w) |=> $stable(fout_o));

  a_r5_div1_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div1_w |-> (fout_o == osc_en_i));

  a_r7_mode_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> $stable(div1_w));

  a_r8_tie_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_i == 3'b001) |-> test_o);

  a_r8_tie_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_i == 3'b101) |-> !test_o);

  a_r9_ref_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_i == 3'b010) |-> (test_o == ref_div_o));

  a_r10_sfb_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_en_i |=> $stable(sfb_w));
endmodule

bind synth_div_chain synth_div_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ref_en_i(ref_en_i), .osc_en_i(osc_en_i),
  .sclk_en_i(sclk_en_i), .t_i(t_i), .ref_div_o(ref_div_o), .fb_o(fb_o),
  .fout_o(fout_o), .test_o(test_o), .div1_w(div1_w), .sfb_w(sfb_w)
);

// File: tb/sim_synth_div_chain.sv
`timescale 1ns/1ps
module sim_synth_div_chain;
  localparam int M_W = 9;
  localparam int MAX_CYC = 200000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ref_en = 0, osc_en = 0, sclk_en = 0, sreg = 0;
  logic [M_W-1:0] m_r = 9'd4;
  logic [1:0] n_r = 2'b00;
  logic [2:0] t_r = 3'b000;
  logic ref_div, fb, fout, test;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // model state
  int rpos, fcnt, scnt, opos, odiv, d4pos;
  bit rw, fw, sw, oq, d4w;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  synth_div_chain #(.M_W(M_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ref_en_i(ref_en), .osc_en_i(osc_en),
    .sclk_en_i(sclk_en), .m_i(m_r), .n_i(n_r), .t_i(t_r), .sreg_i(sreg),
    .ref_div_o(ref_div), .fb_o(fb), .fout_o(fout), .test_o(test)
  );

  // {t[21:19], n[18:17], m[16:8], steps[7:0]}
  localparam logic [21:0] VEC [0:9] = '{
    {3'b000, 2'b00, 9'd3, 8'd40},
    {3'b001, 2'b01, 9'd5, 8'd40},
    {3'b010, 2'b10, 9'd1, 8'd60},
    {3'b011, 2'b11, 9'd0, 8'd40},
    {3'b100, 2'b01, 9'd7, 8'd50},
    {3'b101, 2'b10, 9'd2, 8'd40},
    {3'b110, 2'b00, 9'd4, 8'd60},
    {3'b111, 2'b11, 9'd6, 8'd50},
    {3'b111, 2'b10, 9'd3, 8'd80},
    {3'b100, 2'b11, 9'd2, 8'd40}
  };

  function automatic int ratio_of(input logic [1:0] c);
    case (c)
      2'b00: return 2;
      2'b01: return 4;
      2'b10: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic model_reset();
    rpos = 15; rw = 0; fcnt = 0; fw = 0; scnt = 0; sw = 0;
    opos = 1; odiv = 2; oq = 0; d4pos = 3; d4w = 0;
  endtask

  task automatic model_update(input bit re, input bit oe, input bit se);
    int ld;
    bit tick;
    ld = (m_r == 0) ? 1 : int'(m_r);
    tick = 0;
    if (re) begin rpos = (rpos + 1) % 16; rw = (rpos < 8); end
    if (oe) begin
      if (fcnt == 0) begin fcnt = ld - 1; fw = ~fw; end else fcnt--;
      if (opos == odiv - 1) begin
        opos = 0; odiv = ratio_of(n_r); oq = 1; tick = 1;
      end else begin
        opos++; oq = (opos < odiv / 2);
      end
    end
    if (se) begin
      if (scnt == 0) begin scnt = ld - 1; sw = ~sw; end else scnt--;
    end
    if (tick) begin d4pos = (d4pos + 1) % 4; d4w = (d4pos < 2); end
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  task automatic chk_int(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic compare_all();
    bit fexp, texp;
    string ttag;
    fexp = (odiv == 1) ? osc_en : oq;
    case (t_r)
      3'b000: begin texp = sreg; ttag = "R8 sreg"; end
      3'b001: begin texp = 1'b1; ttag = "R8 high"; end
      3'b010: begin texp = rw;   ttag = "R9 ref"; end
      3'b011: begin texp = fw;   ttag = "R9 fb"; end
      3'b100: begin texp = fexp; ttag = "R9 fout"; end
      3'b101: begin texp = 1'b0; ttag = "R8 low"; end
      3'b110: begin texp = sw;   ttag = "R10 serial M"; end
      default: begin texp = d4w; ttag = "R10 fout div4"; end
    endcase
    chk(ref_div, rw, "R1 ref_div");
    chk(fb, fw, "R2 fb");
    chk(fout, fexp, (odiv == 1) ? "R3,R5 fout" : "R3,R4 fout");
    chk(test, texp, ttag);
  endtask

  task automatic step(input bit re, input bit oe, input bit se);
    @(negedge clk);
    ref_en = re; osc_en = oe; sclk_en = se; sreg = cyc[1];
    @(posedge clk);
    model_update(re, oe, se);
    #1;
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; ref_en = 0; osc_en = 0; sclk_en = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    model_reset();
  endtask

  // oscillator enables every cycle until fb changes
  task automatic fb_gap(output int k);
    bit prev;
    prev = fb; k = 0;
    do begin step(0, 1, 0); k++; end while (fb == prev && k < 1000);
  endtask

  task automatic fout_gap(output int k);
    bit prev;
    prev = fout; k = 0;
    do begin step(0, 1, 0); k++; end while (fout == prev && k < 1000);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int k;
    model_reset();
    do_reset();
    #1;
    // reset state
    chk(ref_div, 1'b0, "R1 reset");
    chk(fb, 1'b0, "R2 reset");
    chk(fout, 1'b0, "R4 reset");

    // vector table with unrelated enable rates
    foreach (VEC[i]) begin
      t_r = VEC[i][21:19]; n_r = VEC[i][18:17]; m_r = VEC[i][16:8];
      for (int s = 0; s < int'(VEC[i][7:0]); s++)
        step((cyc % 2) == 0, (cyc % 5) != 4, (cyc % 3) == 0);
    end

    // R6: M change mid count keeps the old half period
    do_reset();
    t_r = 3'b011; m_r = 9'd6; n_r = 2'b00;
    step(0, 1, 0);
    chk(fb, 1'b1, "R2 first enable toggles");
    step(0, 1, 0); step(0, 1, 0);
    m_r = 9'd2;
    fb_gap(k); chk_int(k, 4, "R6 old M finishes");
    fb_gap(k); chk_int(k, 2, "R6 new M applied");

    // R2: M of zero acts as one
    m_r = 9'd0;
    fb_gap(k); fb_gap(k); chk_int(k, 1, "R2 M zero");

    // R7: N change mid period keeps the old ratio
    do_reset();
    t_r = 3'b100; n_r = 2'b10; m_r = 9'd3;
    step(0, 1, 0);
    chk(fout, 1'b1, "R4 first enable starts period");
    step(0, 1, 0); step(0, 1, 0); step(0, 1, 0);
    n_r = 2'b00;
    fout_gap(k); chk_int(k, 1, "R7 old high half");
    fout_gap(k); chk_int(k, 4, "R7 old low half");
    fout_gap(k); chk_int(k, 1, "R7 new high half");
    fout_gap(k); chk_int(k, 1, "R7 new low half");

    // R5: divide by one follows enable, including an idle cycle
    n_r = 2'b11;
    fout_gap(k);
    step(0, 1, 0); step(0, 1, 0);
    step(0, 0, 0); chk(fout, 1'b0, "R5 idle low");
    step(0, 1, 0); chk(fout, 1'b1, "R5 enable high");

    // R3: divide-by-4 period measured in enables
    n_r = 2'b01;
    step(0, 1, 0);
    fout_gap(k); fout_gap(k); chk_int(k, 2, "R3 code 01 half period");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule